// File: doc/BRIEF.md
# Bidirectional-Pin 1K x 4 Static Memory

This block is a static random access memory of 1024 words of 4 bits. It is reached through a 10-bit address, a 4-bit data bus whose pins serve both directions, and three active-low controls: a chip select, a write strobe and an output gate. From these controls the block chooses one of three actions. It can accept the bus value as write data, drive the addressed word onto the bus, or leave the pins floating so that other devices can use the shared bus.

The storage sits inside a clocked chip. Reads are combinational from the address to the pins, so a new address shows its word before the next clock edge. A write behaves as it does on an asynchronous part: the data is committed when the write window closes. The window closes when either the chip select or the write strobe is released. In this clocked version, the block samples the address and the pin data on every edge while the window is open, and stores the last sample on the first edge after the window has closed. Storage contents are not defined until a location has been written.

Top module: `nsram_core`

## Requirements
- R1: The array holds 1024 words of 4 bits, selected by the 10-bit `addr`. A read returns the value most recently committed to that address.
- R2: While `cs_n` is 1, the pins are never driven and nothing is stored, whatever `wr_n` and `oe_n` are.
- R3: The pins carry the word at the current `addr` only when `cs_n`=0, `wr_n`=1 and `oe_n`=0. They follow a change of `addr` within the same clock cycle, with no edge needed.
- R4: While `cs_n`=0 and `wr_n`=0 (the write window), the pins are not driven, even when `oe_n` is 0.
- R5: While `cs_n`=0, `wr_n`=1 and `oe_n`=1, the pins are not driven.
- R6: When the write window closes because `wr_n` rises, the block stores the word at the first clock edge on which the window is seen closed. The address and data stored are those sampled at the last edge while the window was open. The word can be read right after that edge.
- R7: When the write window closes because `cs_n` rises, the word is committed under the same rule as R6.
- R8: If the address or data change while the window stays open, only the last sampled pair is stored. Addresses presented earlier in the same window keep their old contents.
- R9: While `rst_n` is 0, synchronously, the pins are never driven. A write window that is open when reset is applied is dropped and stores nothing. Reset does not clear the stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the write window |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 10 | Word address |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output gate |
| dq | inout | 4 | Shared data pins, driven only during a read |

## Verification
The bench drives the shared pins through its own tristate driver. During every non-read control combination it drives a value that differs from the stored word and expects to see exactly that value back. A design that drove the pins during a write, while deselected, or with the output gate off would corrupt that value. The bench closes write windows both through the strobe and through the chip select. It also changes the address inside an open window and aborts a window with reset. A design that committed on the wrong edge, stored the first sample instead of the last, or let an aborted write through would then read back a wrong word. Reads at the address extremes 0 and 1023, and reads whose address changes every cycle, expose decode errors and any read path that waits for an extra clock edge.

// File: rtl/nsram_pkg.sv
// Package nsram_pkg
// Shared types for the static memory: the decoded access kind.
// Assumes: the three controls are active low and already synchronous to clk.
package nsram_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,  // chip not selected
        ACC_READ  = 2'd1,  // selected, strobe high, gate low
        ACC_WRITE = 2'd2,  // selected, strobe low
        ACC_QUIET = 2'd3   // selected, strobe high, gate high
    } acc_kind_e;

endpackage

// File: rtl/nsram_decode.sv
// Module nsram_decode
// Turns the three active-low controls into a read drive enable and a
// write-window flag. A write always wins over the output gate.
// Assumes: reset low forces the pins quiet.
module nsram_decode
    import nsram_pkg::*;
(
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic oe_n,
    output logic drive_en,
    output logic wr_req
);

    acc_kind_e kind;

    // Classify the access from the control pins, chip select first.
    always_comb begin
        if (cs_n)       kind = ACC_IDLE;
        else if (!wr_n) kind = ACC_WRITE;
        else if (!oe_n) kind = ACC_READ;
        else            kind = ACC_QUIET;
    end

    // Derive the pin drive and the write window from the access kind.
    always_comb begin
        drive_en = rst_n && (kind == ACC_READ);
        wr_req   = (kind == ACC_WRITE);
    end

    // The pins are never driven while a write window is open.
    always_comb begin
        AST_NO_DRIVE_IN_WRITE: assert (!(drive_en && wr_req)); // R4
    end

endmodule

// File: rtl/nsram_wcapture.sv
// Module nsram_wcapture
// Samples the address and pin data on every edge while the write window is
// open. Raises commit on the first edge at which the window is seen closed.
// Assumes: the window flag comes straight from the decode.
module nsram_wcapture #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);

    logic wr_prev;

    // Remember whether the window was open at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b0;
        else        wr_prev <= wr_req;
    end

    // Keep the latest address and data seen while the window is open.
    always_ff @(posedge clk) begin
        if (wr_req) begin
            commit_addr <= addr;
            commit_data <= din;
        end
    end

    // Commit once the window has closed, never while in reset.
    always_comb commit = rst_n && wr_prev && !wr_req;

    AST_COMMIT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(wr_req)); // R6

    AST_RESET_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !commit); // R9

endmodule

// File: rtl/nsram_array.sv
// Module nsram_array
// Word storage with one write port, clocked, and one combinational read port.
// Assumes: contents start undefined and are never cleared.
module nsram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a committed word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the addressed word without waiting for a clock edge.
    always_comb rdata = mem[raddr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata))); // R1

endmodule

// File: rtl/nsram_core.sv
// Module nsram_core
// 1K x 4 static memory with shared bidirectional data pins and three
// active-low controls. Writes close on the release of chip select or strobe.
// Assumes: the controls and the address are synchronous to clk.
module nsram_core #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              oe_n,
    inout  wire  [DATA_W-1:0] dq
);

    logic              drv_en;
    logic              wr_req;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] pin_in;

    nsram_decode u_decode (
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .oe_n     (oe_n),
        .drive_en (drv_en),
        .wr_req   (wr_req)
    );

    nsram_wcapture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wcap (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (wr_req),
        .addr        (addr),
        .din         (pin_in),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    nsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (commit_addr),
        .wdata (commit_data),
        .raddr (addr),
        .rdata (rdata)
    );

    // Pin buffers: drive out during a read, otherwise float and listen.
    assign dq     = drv_en ? rdata : {DATA_W{1'bz}};
    assign pin_in = dq;

    AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !drv_en); // R2

    AST_GATE_OFF_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drv_en); // R5

    AST_DESELECT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !commit); // R2

endmodule

// File: tb/nsram_core_test.sv
// Bench nsram_core_test
// Behavioural reference model (arrays, integers) updated on every rising
// edge. The pins are compared with the model at every falling edge.
module nsram_core_test;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] addr = '0;
    logic       cs_n = 1'b0;
    logic       wr_n = 1'b1;
    logic       oe_n = 1'b0;
    logic       tb_en = 1'b1;
    logic [3:0] tb_val = 4'hA;
    wire  [3:0] dq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    string rd_tag = "R3";

    int  ref_mem [1024];
    bit  known   [1024];
    bit  win_prev = 1'b0;
    int  cap_addr = 0;
    int  cap_data = 0;

    assign dq = tb_en ? tb_val : 4'bzzzz;

    always #(CLK_P/2) clk = ~clk;

    nsram_core uut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .cs_n  (cs_n),
        .wr_n  (wr_n),
        .oe_n  (oe_n),
        .dq    (dq)
    );

    function automatic logic [3:0] pat(input int a);
        return 4'(1 + (a % 15));
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    // Reference model: the write window and its commit rule.
    always @(posedge clk) begin
        bit win;
        win = !cs_n && !wr_n;
        if (!rst_n) begin
            win_prev = 1'b0;
        end else begin
            if (win_prev && !win) begin
                ref_mem[cap_addr] = cap_data;
                known[cap_addr]   = 1'b1;
            end
            if (win) begin
                cap_addr = int'(addr);
                cap_data = int'(dq);
            end
            win_prev = win;
        end
    end

    // Compare the pins with the model at every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            if (rst_n && !cs_n && wr_n && !oe_n) begin
                if (known[addr]) check(dq, 4'(ref_mem[addr]), rd_tag);
            end else if (tb_en) begin
                if (!rst_n)     check(dq, tb_val, "R9");
                else if (cs_n)  check(dq, tb_val, "R2");
                else if (!wr_n) check(dq, tb_val, "R4");
                else            check(dq, tb_val, "R5");
            end
        end
    end

    task automatic drv(input logic c, input logic w, input logic o, input int a,
                       input logic en, input logic [3:0] v);
        @(posedge clk); #1;
        cs_n = c; wr_n = w; oe_n = o; addr = 10'(a); tb_en = en; tb_val = v;
    endtask

    task automatic rd(input int a);
        drv(1'b0, 1'b1, 1'b0, a, 1'b0, 4'h0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            known[i] = 1'b0;
            ref_mem[i] = 0;
        end
        // R9: reset with a read combination applied keeps the pins floating.
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1; cs_n = 1'b1;

        // R1/R6: fill every address, close each window through the strobe.
        for (int a = 0; a < 1024; a++) begin
            drv(1'b0, 1'b0, 1'b1, a, 1'b1, pat(a));
            drv(1'b0, 1'b1, 1'b1, a, 1'b1, pat(a) ^ 4'hF);
        end
        rd_tag = "R1";
        for (int a = 0; a < 1024; a++) rd(a);

        // R3: the address changes every cycle, including both extremes.
        rd_tag = "R3";
        rd(1023); rd(0); rd(512); rd(1023); rd(1);

        // R2/R4/R5: float checks with the inverted stored value on the bus.
        for (int k = 0; k < 3; k++) begin
            int a;
            logic [3:0] s;
            a = (k == 0) ? 3 : (k == 1) ? 100 : 1023;
            s = pat(a);
            drv(1'b0, 1'b1, 1'b1, a, 1'b1, ~s);      // R5
            drv(1'b1, 1'b1, 1'b0, a, 1'b1, ~s);      // R2
            drv(1'b1, 1'b0, 1'b0, a, 1'b1, ~s);      // R2: write while deselected
            drv(1'b1, 1'b1, 1'b1, a, 1'b1, ~s);
            rd_tag = "R2";
            rd(a);
            drv(1'b0, 1'b0, 1'b0, a, 1'b1, ~s);      // R4: gate low during write
            drv(1'b0, 1'b1, 1'b1, a, 1'b1, 4'h0);
            rd_tag = "R6";
            rd(a);
        end

        // R7: close the window by releasing chip select.
        drv(1'b0, 1'b0, 1'b1, 200, 1'b1, 4'h9);
        drv(1'b1, 1'b0, 1'b1, 200, 1'b1, 4'h5);
        rd_tag = "R7";
        rd(200);

        // R8: address and data move inside one open window.
        drv(1'b0, 1'b0, 1'b1, 20, 1'b1, 4'hC);
        drv(1'b0, 1'b0, 1'b1, 21, 1'b1, 4'hD);
        drv(1'b0, 1'b0, 1'b1, 22, 1'b1, 4'hE);
        drv(1'b0, 1'b1, 1'b1, 22, 1'b1, 4'h0);
        rd_tag = "R8";
        rd(20); rd(21); rd(22);

        // R9: reset during an open window drops the write.
        drv(1'b0, 1'b0, 1'b1, 7, 1'b1, 4'h3);
        @(posedge clk); #1; rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1; wr_n = 1'b1; oe_n = 1'b1;
        rd_tag = "R9";
        rd(7);
        drv(1'b1, 1'b1, 1'b1, 0, 1'b1, 4'h6);
        @(posedge clk); #1;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule